// File: doc/BRIEF.md
# Byte-Port Ethernet Frame Mailbox

This peripheral lets a processor exchange Ethernet frames with a network-side byte stream. It holds one buffer for a received frame and one for a frame being sent. Each buffer is up to `FRAME_MAX` bytes, default 1514. Software moves the payload one byte per register access through two data ports. It reads counts and a busy flag from the register bus, and clears the done flags through one interrupt-control register whose write is priority-decoded. A level interrupt follows the done flags.

On the network side, incoming frames arrive as a byte stream with valid, ready and last. A frame is taken only while the block is idle, meaning busy is low. Frames that are too long are swallowed and discarded. Once software has written the number of bytes it announced, the transmit buffer plays the frame out on an outgoing byte stream. While that playback runs, the transmit buffer refuses new data-port writes.

Top module: `frame_mailbox`

## Requirements
- R1: Only the 6-bit offset is decoded. Offset 0x00 returns characters 1-4 of the `ID_SIG` parameter and 0x04 returns characters 5-8, with the first character of each group in bits 31:24. For the default "FRMBOX01" these are 0x46524D42 and 0x4F583031. Offsets 0x18 and 0x20, and every offset not listed in these requirements, read as zero.
- R2: After reset, busy (0x08 bit 0) reads 1, the receive count (0x0C) and transmit count (0x10) read 0, interrupt control (0x14) reads 0, `irq` is low and `rx_ready` is low.
- R3: Read data appears on `reg_rdata` on the cycle after the `reg_rd` strobe. `irq` is high exactly when interrupt control is nonzero.
- R4: Interrupt control has transmit-done at bit 0, receive-done at bit 1 and test at bit 31. Reading it returns the current value and then clears the test bit, once per strobe.
- R5: A write to 0x14 is decoded by priority. If bit 0 is set, only transmit-done is cleared. Otherwise, if bit 1 is set, only receive-done is cleared. Otherwise, if bit 31 is set, a soft reset clears both counts and both buffer pointers and then sets the test bit. A zero write changes no flag. After the write, busy equals 1 if interrupt control is nonzero and 0 otherwise.
- R6: A new frame is accepted only when busy is 0 and the receive count is below `FRAME_MAX`. Otherwise `rx_ready` stays low at the frame start.
- R7: When the last byte of an accepted frame shorter than `FRAME_MAX` arrives, the receive count is loaded with the frame length, the read pointer is zeroed, busy is set and receive-done is set.
- R8: A frame of `FRAME_MAX` bytes or more is consumed in full and discarded. It does not set receive-done or busy and does not change the receive count.
- R9: Reading 0x1C while the receive count is nonzero returns the next stored byte in bits 7:0, advances the read pointer and decrements the count. With a zero count, the read returns 0 and changes nothing.
- R10: Writing 0x10 loads the transmit count with the written value if that value is at most `FRAME_MAX`, and with 0 otherwise. The same write resets the transmit write pointer.
- R11: Each write to 0x20 stores bits 7:0 and advances the write pointer. When the pointer equals the transmit count, or reaches `FRAME_MAX`, the frame is played out in order on `tx_*` with `tx_last` on the final byte. In the same step the transmit count and pointer are zeroed and transmit-done and busy are set. Data and last hold while `tx_ready` is low.
- R12: Writes to 0x20 while a frame is being played out are ignored.
- R13: Writes to 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Level interrupt |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte valid |
| rx_last | input | 1 | Final byte of received frame |
| rx_ready | output | 1 | Block takes the received byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_last | output | 1 | Final byte of outgoing frame |
| tx_ready | input | 1 | Sink takes the outgoing byte |

## Verification
The bench checks the interrupt-control write priority with two flags pending. A decoder without priority would clear both flags, or would treat bit 31 as a soft reset and wipe the receive count. The size boundary is tested on both sides: a frame of exactly `FRAME_MAX` bytes must vanish, while one byte fewer must be kept whole. With the transmit count at 0, the frame must go out only at the `FRAME_MAX`-th write. A data-port write during a backpressured playback must not leak into the next frame, and a read from an empty receive port must leave the count at zero instead of wrapping it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam logic [5:0] OFS_ID_HI   = 6'h00;
    localparam logic [5:0] OFS_ID_LO   = 6'h04;
    localparam logic [5:0] OFS_BUSY    = 6'h08;
    localparam logic [5:0] OFS_RXCNT   = 6'h0C;
    localparam logic [5:0] OFS_TXCNT   = 6'h10;
    localparam logic [5:0] OFS_IRQCTL  = 6'h14;
    localparam logic [5:0] OFS_IRQINFO = 6'h18;
    localparam logic [5:0] OFS_RXPORT  = 6'h1C;
    localparam logic [5:0] OFS_TXPORT  = 6'h20;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_STORE = 2'd1,
        RX_DROP  = 2'd2
    } rx_state_e;

    typedef enum logic {
        TX_FILL = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // interrupt flags; the bit positions below are visible to software
    typedef struct packed {
        logic test;
        logic rx_done;
        logic tx_done;
    } irq_flags_t;

    function automatic logic [31:0] flags_to_word(irq_flags_t f);
        return {f.test, 29'd0, f.rx_done, f.tx_done};
    endfunction

    function automatic irq_flags_t word_to_flags(logic [31:0] w);
        irq_flags_t f;
        f.test    = w[31];
        f.rx_done = w[1];
        f.tx_done = w[0];
        return f;
    endfunction

endpackage

// File: rtl/mbx_irq_ctl.sv
module mbx_irq_ctl
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  irq_flags_t ctl_bits,
    input  logic       ctl_rd,
    input  logic       tx_evt,
    input  logic       rx_evt,
    output irq_flags_t flags,
    output logic       busy,
    output logic       soft_clr
);

    irq_flags_t flags_n;
    irq_flags_t after_wr;
    logic       busy_n;

    assign soft_clr = ctl_wr && !ctl_bits.tx_done && !ctl_bits.rx_done && ctl_bits.test;

    always_comb begin
        after_wr = flags;
        if (ctl_rd) after_wr.test = 1'b0;
        if (ctl_wr) begin
            if (ctl_bits.tx_done)      after_wr.tx_done = 1'b0;
            else if (ctl_bits.rx_done) after_wr.rx_done = 1'b0;
            else if (ctl_bits.test)    after_wr = '{test: 1'b1, rx_done: 1'b0, tx_done: 1'b0};
        end
        flags_n = after_wr;
        if (tx_evt) flags_n.tx_done = 1'b1;
        if (rx_evt) flags_n.rx_done = 1'b1;
        busy_n = busy;
        if (ctl_wr) busy_n = |after_wr;
        if (tx_evt || rx_evt) busy_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            busy  <= 1'b1;
        end else begin
            flags <= flags_n;
            busy  <= busy_n;
        end
    end

    // R4: a read with no write leaves the test bit clear
    a_r4_test_clear: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd && !ctl_wr) |=> !flags.test)
        else $error("test bit survived a control read");

    // R5: a write with bit 0 clears transmit-done and leaves receive-done alone
    a_r5_tx_first: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_bits.tx_done && !tx_evt && !rx_evt) |=>
        (!flags.tx_done && flags.rx_done == $past(flags.rx_done)))
        else $error("control write priority broken");

    // R7: a receive event raises busy and receive-done
    a_r7_rx_evt: assert property (@(posedge clk) disable iff (rst)
        rx_evt |=> (busy && flags.rx_done))
        else $error("receive event not recorded");

endmodule

// File: rtl/mbx_rx_path.sv
module mbx_rx_path
    import mbx_pkg::*;
#(
    parameter int FRAME_MAX = 1514,
    parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_clr,
    input  logic             busy,
    input  logic             pop,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    output logic [7:0]       head_byte,
    output logic [CNT_W-1:0] count,
    output logic             done_evt
);

    localparam logic [CNT_W-1:0] MAX_C    = CNT_W'(FRAME_MAX);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_MAX - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [7:0]       mem [FRAME_MAX];
    rx_state_e        state, st_n;
    logic [CNT_W-1:0] wptr, wptr_n, rptr, rptr_n, cnt_n, idx, len;
    logic             beat, store, commit, can_take;

    assign can_take  = !busy && (count < MAX_C);
    assign s_ready   = (state == RX_IDLE) ? can_take : 1'b1;
    assign beat      = s_valid && s_ready;
    assign head_byte = (count != '0) ? mem[rptr] : 8'd0;
    assign done_evt  = commit && !soft_clr;

    always_comb begin
        st_n   = state;
        wptr_n = wptr;
        rptr_n = rptr;
        cnt_n  = count;
        commit = 1'b0;
        store  = 1'b0;
        len    = '0;
        idx    = (state == RX_IDLE) ? '0 : wptr;
        if (pop && count != '0) begin
            rptr_n = rptr + ONE;
            cnt_n  = count - ONE;
        end
        if (beat) begin
            unique case (state)
                RX_IDLE, RX_STORE: begin
                    if (idx >= LAST_IDX) begin
                        st_n = s_last ? RX_IDLE : RX_DROP;
                    end else begin
                        store = 1'b1;
                        if (s_last) begin
                            commit = 1'b1;
                            len    = idx + ONE;
                            st_n   = RX_IDLE;
                        end else begin
                            st_n   = RX_STORE;
                            wptr_n = idx + ONE;
                        end
                    end
                end
                RX_DROP: if (s_last) st_n = RX_IDLE;
                default: st_n = RX_IDLE;
            endcase
        end
        if (commit) begin
            cnt_n  = len;
            rptr_n = '0;
        end
        if (soft_clr) begin
            cnt_n  = '0;
            rptr_n = '0;
            wptr_n = '0;
            if (st_n == RX_STORE) st_n = RX_DROP;
        end
    end

    always_ff @(posedge clk) begin
        if (store) mem[idx] <= s_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            state <= st_n;
            wptr  <= wptr_n;
            rptr  <= rptr_n;
            count <= cnt_n;
        end
    end

    // R6: no frame starts or completes while busy
    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && busy) |-> !done_evt)
        else $error("frame accepted while busy");

    a_r6_busy_idle: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && busy) |=> (state == RX_IDLE))
        else $error("frame started while busy");

    // R8: the stored count never reaches the frame limit
    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        count < MAX_C)
        else $error("receive count reached limit");

    // R9: a pop with a nonzero count decrements by one
    a_r9_pop_step: assert property (@(posedge clk) disable iff (rst)
        (pop && count != '0 && !commit && !soft_clr) |=> (count == $past(count) - ONE))
        else $error("pop did not decrement");

    // R9: a pop on an empty buffer leaves the count at zero
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && count == '0 && !commit) |=> (count == '0))
        else $error("pop on empty changed count");

endmodule

// File: rtl/mbx_tx_path.sv
module mbx_tx_path
    import mbx_pkg::*;
#(
    parameter int FRAME_MAX = 1514,
    parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_clr,
    input  logic             cnt_wr,
    input  logic [31:0]      cnt_wdata,
    input  logic             data_wr,
    input  logic [7:0]       data_byte,
    input  logic             m_ready,
    output logic [7:0]       m_data,
    output logic             m_valid,
    output logic             m_last,
    output logic [CNT_W-1:0] count,
    output logic             send_evt
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(FRAME_MAX);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [7:0]       mem [FRAME_MAX];
    tx_state_e        state, st_n;
    logic [CNT_W-1:0] wptr, wptr_n, cnt_n, sptr, sptr_n, len, len_n, wn;
    logic             fill_wr;

    assign m_valid  = (state == TX_SEND);
    assign m_data   = mem[sptr];
    assign m_last   = (sptr == len - ONE);
    assign fill_wr  = (state == TX_FILL) && data_wr;
    assign wn       = wptr + ONE;

    always_comb begin
        st_n     = state;
        wptr_n   = wptr;
        cnt_n    = count;
        sptr_n   = sptr;
        len_n    = len;
        send_evt = 1'b0;
        if (cnt_wr) begin
            cnt_n  = (cnt_wdata <= 32'(FRAME_MAX)) ? cnt_wdata[CNT_W-1:0] : '0;
            wptr_n = '0;
        end
        unique case (state)
            TX_FILL: begin
                if (data_wr) begin
                    if (wn == count || wn >= MAX_C) begin
                        send_evt = 1'b1;
                        st_n     = TX_SEND;
                        len_n    = wn;
                        sptr_n   = '0;
                        wptr_n   = '0;
                        cnt_n    = '0;
                    end else begin
                        wptr_n = wn;
                    end
                end
            end
            TX_SEND: begin
                if (m_ready) begin
                    if (m_last) st_n = TX_FILL;
                    else        sptr_n = sptr + ONE;
                end
            end
            default: st_n = TX_FILL;
        endcase
        if (soft_clr) begin
            cnt_n  = '0;
            wptr_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_wr) mem[wptr] <= data_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_FILL;
            wptr  <= '0;
            count <= '0;
            sptr  <= '0;
            len   <= '0;
        end else begin
            state <= st_n;
            wptr  <= wptr_n;
            count <= cnt_n;
            sptr  <= sptr_n;
            len   <= len_n;
        end
    end

    // R10: the transmit count never exceeds the frame limit
    a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= MAX_C)
        else $error("transmit count above limit");

    // R11: outgoing byte holds under backpressure
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)))
        else $error("outgoing byte changed while stalled");

    // R11: the stream stops after its final byte
    a_r11_end: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && m_last) |=> !m_valid)
        else $error("stream continued past last");

    // R12: data-port writes during playback leave the write pointer alone
    a_r12_ignore: assert property (@(posedge clk) disable iff (rst)
        (state == TX_SEND && data_wr && !cnt_wr && !soft_clr) |=> (wptr == $past(wptr)))
        else $error("write accepted during playback");

endmodule

// File: rtl/frame_mailbox.sv
module frame_mailbox
    import mbx_pkg::*;
#(
    parameter int          FRAME_MAX = 1514,
    parameter logic [63:0] ID_SIG    = "FRMBOX01"
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready
);

    localparam int CNT_W = $clog2(FRAME_MAX + 1);

    irq_flags_t       flags;
    logic             busy, soft_clr, tx_evt, rx_evt;
    logic             ctl_wr, ctl_rd, pop, txc_wr, txd_wr;
    logic [7:0]       head_byte;
    logic [CNT_W-1:0] rx_count, tx_count;
    logic [31:0]      rd_word;

    assign ctl_wr = reg_wr && (reg_addr == OFS_IRQCTL);
    assign ctl_rd = reg_rd && (reg_addr == OFS_IRQCTL);
    assign pop    = reg_rd && (reg_addr == OFS_RXPORT);
    assign txc_wr = reg_wr && (reg_addr == OFS_TXCNT);
    assign txd_wr = reg_wr && (reg_addr == OFS_TXPORT);
    assign irq    = |flags;

    mbx_irq_ctl u_irq (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_bits (word_to_flags(reg_wdata)),
        .ctl_rd   (ctl_rd),
        .tx_evt   (tx_evt),
        .rx_evt   (rx_evt),
        .flags    (flags),
        .busy     (busy),
        .soft_clr (soft_clr)
    );

    mbx_rx_path #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .soft_clr  (soft_clr),
        .busy      (busy),
        .pop       (pop),
        .s_data    (rx_data),
        .s_valid   (rx_valid),
        .s_last    (rx_last),
        .s_ready   (rx_ready),
        .head_byte (head_byte),
        .count     (rx_count),
        .done_evt  (rx_evt)
    );

    mbx_tx_path #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .soft_clr  (soft_clr),
        .cnt_wr    (txc_wr),
        .cnt_wdata (reg_wdata),
        .data_wr   (txd_wr),
        .data_byte (reg_wdata[7:0]),
        .m_ready   (tx_ready),
        .m_data    (tx_data),
        .m_valid   (tx_valid),
        .m_last    (tx_last),
        .count     (tx_count),
        .send_evt  (tx_evt)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_ID_HI:  rd_word = ID_SIG[63:32];
            OFS_ID_LO:  rd_word = ID_SIG[31:0];
            OFS_BUSY:   rd_word = {31'd0, busy};
            OFS_RXCNT:  rd_word = 32'(rx_count);
            OFS_TXCNT:  rd_word = 32'(tx_count);
            OFS_IRQCTL: rd_word = flags_to_word(flags);
            OFS_RXPORT: rd_word = {24'd0, head_byte};
            default:    rd_word = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= 32'd0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    // R1: identifier word returned one cycle after its strobe
    a_r1_id_read: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_ID_HI) |=> (reg_rdata == ID_SIG[63:32]))
        else $error("identifier read wrong");

    // R11: a transmit send raises busy and transmit-done
    a_r11_send_flags: assert property (@(posedge clk) disable iff (rst)
        tx_evt |=> (busy && flags.tx_done && tx_valid && tx_count == '0))
        else $error("send did not update state");

endmodule

// File: tb/frame_mailbox_tb.sv
module frame_mailbox_tb;

    localparam int CLK_P = 10;
    localparam int FMAX  = 1514;

    localparam logic [5:0] A_IDH = 6'h00, A_IDL = 6'h04, A_BUSY = 6'h08,
                           A_RXC = 6'h0C, A_TXC = 6'h10, A_CTL = 6'h14,
                           A_INFO = 6'h18, A_RXP = 6'h1C, A_TXP = 6'h20;

    // transmit count write value, expected readback (R10)
    localparam logic [63:0] TXC_VEC [6] = '{
        {32'd5,          32'd5},
        {32'd1514,       32'd1514},
        {32'd1515,       32'd0},
        {32'hFFFF_FFFF,  32'd0},
        {32'd1,          32'd1},
        {32'd0,          32'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit bp_mode = 1'b0;
    logic [7:0] cap [2048];
    int cap_n = 0;
    int last_at = -1;
    int frames = 0;

    frame_mailbox u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    always #(CLK_P / 2) clk = ~clk;

    // outgoing stream monitor and backpressure generator
    always @(negedge clk) begin
        if (tx_valid && tx_ready) begin
            if (cap_n < 2048) cap[cap_n] = tx_data;
            if (tx_last) begin
                last_at = cap_n;
                frames  = frames + 1;
            end
            cap_n = cap_n + 1;
        end
        cyc = cyc + 1;
        tx_ready = bp_mode ? ((cyc % 8) == 0) : 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(i ^ seed);
            rx_last  = (i == len - 1);
            while (!rx_ready) @(negedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        while (frames < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog all-reqs act=timeout exp=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int f0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        chk("R2 irq", {31'd0, irq}, 32'd0);
        chk("R2 rx_ready", {31'd0, rx_ready}, 32'd0);
        rd(A_BUSY, v); chk("R2 busy", v, 32'd1);
        rd(A_RXC, v);  chk("R2 rxcount", v, 32'd0);
        rd(A_TXC, v);  chk("R2 txcount", v, 32'd0);
        rd(A_CTL, v);  chk("R2 intctl", v, 32'd0);

        // R1 identifier and zero reads
        rd(A_IDH, v);  chk("R1 id hi", v, 32'h46524D42);
        rd(A_IDL, v);  chk("R1 id lo", v, 32'h4F583031);
        rd(A_INFO, v); chk("R1 info", v, 32'd0);
        rd(A_TXP, v);  chk("R1 txport", v, 32'd0);
        rd(6'h3C, v);  chk("R1 unmapped", v, 32'd0);

        // R10 clamp table
        for (int i = 0; i < 6; i++) begin
            wr(A_TXC, TXC_VEC[i][63:32]);
            rd(A_TXC, v);
            chk("R10 count clamp", v, TXC_VEC[i][31:0]);
        end

        // R5 zero write recomputes busy
        wr(A_CTL, 32'd0);
        rd(A_BUSY, v); chk("R5 busy after zero write", v, 32'd0);
        chk("R6 ready when idle", {31'd0, rx_ready}, 32'd1);

        // R7 accept a 5-byte frame
        push_frame(5, 8'h10);
        rd(A_RXC, v);  chk("R7 rxcount", v, 32'd5);
        rd(A_BUSY, v); chk("R7 busy", v, 32'd1);
        rd(A_CTL, v);  chk("R7 intctl", v, 32'd2);
        chk("R3 irq high", {31'd0, irq}, 32'd1);
        chk("R6 ready low when busy", {31'd0, rx_ready}, 32'd0);

        // R9 pop two bytes
        rd(A_RXP, v);  chk("R9 byte0", v, 32'h10);
        rd(A_RXP, v);  chk("R9 byte1", v, 32'h11);
        rd(A_RXC, v);  chk("R9 count", v, 32'd3);

        // R13 read-only writes
        wr(A_RXC, 32'h77); wr(A_BUSY, 32'd0); wr(A_RXP, 32'h5A);
        wr(A_IDH, 32'hFFFF_FFFF); wr(A_INFO, 32'h1);
        rd(A_RXC, v);  chk("R13 rxcount kept", v, 32'd3);
        rd(A_BUSY, v); chk("R13 busy kept", v, 32'd1);
        rd(A_IDH, v);  chk("R13 id kept", v, 32'h46524D42);
        rd(A_RXP, v);  chk("R13 rxport write no pop", v, 32'h12);

        // R11 send a 4-byte frame, low byte only
        wr(A_TXC, 32'd4);
        for (int i = 0; i < 4; i++) wr(A_TXP, 32'h1234_56A1 + 32'(i));
        rd(A_CTL, v);  chk("R11 intctl both", v, 32'd3);
        rd(A_TXC, v);  chk("R11 txcount zeroed", v, 32'd0);
        wait_frames(1);
        chk("R11 length", 32'(cap_n), 32'd4);
        chk("R11 last pos", 32'(last_at), 32'd3);
        for (int i = 0; i < 4; i++) chk("R11 data", {24'd0, cap[i]}, 32'hA1 + 32'(i));

        // R5 priority with two flags pending
        wr(A_CTL, 32'h8000_0003);
        rd(A_CTL, v);  chk("R5 only txdone cleared", v, 32'd2);
        rd(A_RXC, v);  chk("R5 no soft reset", v, 32'd2);
        wr(A_CTL, 32'h8000_0002);
        rd(A_CTL, v);  chk("R5 rxdone cleared", v, 32'd0);
        rd(A_BUSY, v); chk("R5 busy clears", v, 32'd0);

        // R9 drain and empty read
        rd(A_RXP, v);  chk("R9 byte3", v, 32'h13);
        rd(A_RXP, v);  chk("R9 byte4", v, 32'h14);
        rd(A_RXP, v);  chk("R9 empty read", v, 32'd0);
        rd(A_RXC, v);  chk("R9 count stays zero", v, 32'd0);

        // R4/R5 soft reset
        push_frame(3, 8'h40);
        wr(A_CTL, 32'd2);
        wr(A_TXC, 32'd9);
        wr(A_CTL, 32'h8000_0000);
        chk("R3 irq on test", {31'd0, irq}, 32'd1);
        rd(A_RXC, v);  chk("R5 soft rxcount", v, 32'd0);
        rd(A_TXC, v);  chk("R5 soft txcount", v, 32'd0);
        rd(A_CTL, v);  chk("R4 test read", v, 32'h8000_0000);
        rd(A_CTL, v);  chk("R4 test cleared", v, 32'd0);
        chk("R3 irq low", {31'd0, irq}, 32'd0);
        rd(A_BUSY, v); chk("R5 busy held", v, 32'd1);
        wr(A_CTL, 32'd0);

        // R8 oversize dropped, one byte less kept
        push_frame(FMAX, 8'h5C);
        rd(A_CTL, v);  chk("R8 no rxdone", v, 32'd0);
        rd(A_RXC, v);  chk("R8 count unchanged", v, 32'd0);
        rd(A_BUSY, v); chk("R8 busy unchanged", v, 32'd0);
        push_frame(FMAX - 1, 8'h33);
        rd(A_RXC, v);  chk("R7 max frame count", v, 32'(FMAX - 1));
        rd(A_RXP, v);  chk("R7 max frame byte0", v, 32'h33);
        rd(A_RXP, v);  chk("R7 max frame byte1", v, 32'h32);
        wr(A_CTL, 32'd2);

        // R12 write during playback ignored
        cap_n = 0; frames = 0; bp_mode = 1'b1;
        wr(A_TXC, 32'd2);
        wr(A_TXP, 32'h31);
        wr(A_TXP, 32'h32);
        wr(A_TXC, 32'd2);
        wr(A_TXP, 32'h99);
        chk("R12 still sending", {31'd0, tx_valid}, 32'd1);
        wait_frames(1);
        bp_mode = 1'b0;
        wr(A_TXP, 32'h55);
        wr(A_TXP, 32'h66);
        wait_frames(2);
        chk("R12 total bytes", 32'(cap_n), 32'd4);
        chk("R11 backpressured byte0", {24'd0, cap[0]}, 32'h31);
        chk("R12 next frame byte0", {24'd0, cap[2]}, 32'h55);
        chk("R12 next frame byte1", {24'd0, cap[3]}, 32'h66);

        // R10 pointer reset on count write
        cap_n = 0; frames = 0;
        wr(A_TXC, 32'd3);
        wr(A_TXP, 32'hE0);
        wr(A_TXC, 32'd2);
        wr(A_TXP, 32'hE1);
        wr(A_TXP, 32'hE2);
        wait_frames(1);
        chk("R10 ptr reset len", 32'(cap_n), 32'd2);
        chk("R10 ptr reset byte0", {24'd0, cap[0]}, 32'hE1);

        // R11 count zero sends at the limit
        cap_n = 0; frames = 0;
        wr(A_TXC, 32'd0);
        for (int i = 0; i < FMAX - 1; i++) wr(A_TXP, 32'(i));
        chk("R11 not sent early", {31'd0, tx_valid}, 32'd0);
        wr(A_TXP, 32'(FMAX - 1));
        wait_frames(1);
        f0 = cap_n;
        chk("R11 limit length", 32'(f0), 32'(FMAX));
        chk("R11 limit last", 32'(last_at), 32'(FMAX - 1));
        chk("R11 limit tail byte", {24'd0, cap[FMAX - 1]}, 32'((FMAX - 1) & 8'hFF));

        summary();
        $finish;
    end

endmodule